// File: doc/BRIEF.md
# DRAM refresh and initialization sequencer

This block brings a DRAM out of power-up and keeps it refreshed. After reset it stays quiet for a programmable pause. It then runs a fixed number of wake-up refresh cycles on its own authority. Once those are done it raises an init-done flag and starts counting refresh intervals. Every interval adds one entry to a saturating backlog counter. Whenever the backlog, or an outstanding burst, is non-zero and no cycle is running, the block requests the memory bus. When the arbiter answers with a grant, the block runs one refresh cycle.

Each refresh cycle orders the strobes so that the device uses its internal row counter. Column strobe goes low first, then row strobe, and the write strobe stays high. Because of this ordering no address is driven. While a cycle runs, the block owns the strobe lines and flags this on a dedicated output.

A burst request loads a programmable number of back-to-back refresh cycles. This is meant for the periods just before entering and just after leaving self refresh. An urgent flag warns the arbiter when the backlog grows past a threshold. All times are given in clock cycles through parameters.

Top module: `rfs_seq`

## Requirements
- R1: While reset is asserted, row, column and write strobes are high, and request, bus-own, init-done, urgent and burst-active outputs are low.
- R2: For PAUSE_CYC cycles after reset release, no strobe falls and bus-own stays low.
- R3: After the pause, exactly WAKE_CNT refresh cycles run without any grant. Init-done rises in the cycle after the last of them ends. Before init-done, request stays low and grant has no effect.
- R4: In every refresh cycle the column strobe falls T_CSR cycles before the row strobe. The column strobe stays low for the first T_CHR cycles of row-strobe low, then returns high while the row strobe is still low.
- R5: The row strobe stays low for exactly T_RAS cycles. It is then high for at least T_RP cycles before the column strobe may fall again.
- R6: The write strobe is high at all times.
- R7: After init-done, the backlog rises by one every INTERVAL_CYC cycles. It saturates at 2^PEND_W-1, so after a long period without grant exactly that many cycles are served.
- R8: Request is high when init is done, no cycle is running, and the backlog or the burst count is non-zero. A cycle starts in the clock after a request is met by grant. When a cycle completes, it decrements the burst count if that is non-zero, and the backlog otherwise.
- R9: Urgent is high exactly while the backlog exceeds URGENT_LVL.
- R10: A burst pulse after init-done, with no burst outstanding, loads BURST_CNT cycles, and burst-active is high until they complete. A burst pulse before init-done, or while a burst is outstanding, is ignored.
- R11: Bus-own is high from the first cycle of the column-strobe setup through the last precharge cycle, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grant_i | input | 1 | Bus grant from access arbitration |
| burst_req_i | input | 1 | One-cycle pulse requesting a refresh burst |
| req_o | output | 1 | Bus request for a refresh cycle |
| bus_own_o | output | 1 | Block is driving the strobes |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write strobe, active low |
| init_done_o | output | 1 | Power-up pause and wake-up cycles complete |
| urgent_o | output | 1 | Backlog above threshold |
| burst_act_o | output | 1 | Burst cycles outstanding |

## Verification
Several properties are checked on every clock by the in-line assertions:
- the column strobe leads the row strobe at every falling edge and is released before the row strobe rises;
- there is no request before init-done, and init-done rises only after a completed cycle;
- bus ownership is released only at a cycle's end;
- the backlog steps and saturates correctly;
- urgent implies a pending or running refresh.

Other behaviour only the bench scenarios can show, through a behavioural model compared every cycle:
- the exact number of wake-up cycles;
- the interval spacing;
- the saturated backlog being drained to exactly its maximum;
- a burst delivering exactly its count while a second pulse is ignored.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACTIVE, PH_PRECH} phase_t;
  typedef enum logic [1:0] {MD_PAUSE, MD_WAKE, MD_RUN} mode_t;

  // bits needed for a counter spanning 0 .. n-1
  function automatic int ctr_bits(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // total clocks a refresh cycle keeps the bus
  function automatic int cbr_len(input int csr, input int ras, input int rp);
    return csr + ras + rp;
  endfunction
endpackage

// File: rtl/rfs_timer.sv
module rfs_timer #(
  parameter int PERIOD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int W = rfs_pkg::ctr_bits(PERIOD);
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);

  logic [W-1:0] cnt;

  assign tick = en && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!en)    cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rfs_backlog.sv
module rfs_backlog #(
  parameter int PEND_W     = 4,
  parameter int URGENT_LVL = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              dec,
  output logic [PEND_W-1:0] count,
  output logic              urgent
);
  localparam logic [PEND_W-1:0] TOP = '1;

  assign urgent = count > PEND_W'(URGENT_LVL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (inc && !dec) begin
      if (count != TOP) count <= count + 1'b1;
    end else if (dec && !inc) count <= count - 1'b1;
  end

  // R7
  backlog_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec && count != TOP) |=> count == $past(count) + 1'b1);
  // R7
  backlog_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec && count == TOP) |=> count == TOP);
endmodule

// File: rtl/rfs_cbr.sv
module rfs_cbr
  import rfs_pkg::*;
#(
  parameter int T_CSR = 1,
  parameter int T_RAS = 6,
  parameter int T_CHR = 1,
  parameter int T_RP  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic cyc_done,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);
  localparam int CW = ctr_bits(max3(T_CSR, T_RAS, T_RP));

  phase_t        ph;
  logic [CW-1:0] cnt;
  logic          setup_end, active_end;

  assign setup_end  = (ph == PH_SETUP)  && (cnt == CW'(T_CSR - 1));
  assign active_end = (ph == PH_ACTIVE) && (cnt == CW'(T_RAS - 1));
  assign cyc_done   = (ph == PH_PRECH)  && (cnt == CW'(T_RP - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= PH_IDLE;
      cnt <= '0;
    end else begin
      unique case (ph)
        PH_IDLE: if (start) begin ph <= PH_SETUP; cnt <= '0; end
        PH_SETUP:
          if (setup_end) begin ph <= PH_ACTIVE; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        PH_ACTIVE:
          if (active_end) begin ph <= PH_PRECH; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        PH_PRECH:
          if (cyc_done) begin ph <= PH_IDLE; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign busy  = (ph != PH_IDLE);
  assign ras_n = (ph != PH_ACTIVE);
  assign cas_n = !((ph == PH_SETUP) || ((ph == PH_ACTIVE) && (cnt < CW'(T_CHR))));
  assign we_n  = 1'b1;

  // R4
  cas_leads_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n)));
  // R4
  cas_rises_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> cas_n);
  // R11
  start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/rfs_seq.sv
module rfs_seq
  import rfs_pkg::*;
#(
  parameter int PAUSE_CYC    = 20000,
  parameter int WAKE_CNT     = 8,
  parameter int INTERVAL_CYC = 1560,
  parameter int T_CSR        = 1,
  parameter int T_RAS        = 6,
  parameter int T_CHR        = 1,
  parameter int T_RP         = 4,
  parameter int BURST_CNT    = 1024,
  parameter int PEND_W       = 4,
  parameter int URGENT_LVL   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic grant_i,
  input  logic burst_req_i,
  output logic req_o,
  output logic bus_own_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o,
  output logic init_done_o,
  output logic urgent_o,
  output logic burst_act_o
);
  localparam int WKW = ctr_bits(WAKE_CNT + 1);
  localparam int BSW = ctr_bits(BURST_CNT + 1);

  mode_t            mode;
  logic [WKW-1:0]   wake_done;
  logic [BSW-1:0]   burst_left;
  logic [PEND_W-1:0] pend;
  logic pause_tick, iv_tick, busy, cyc_done;
  logic wake_start, run_req, start, pend_dec, burst_take, in_run;

  assign in_run     = (mode == MD_RUN);
  assign wake_start = (mode == MD_WAKE) && !busy && (wake_done != WKW'(WAKE_CNT));
  assign run_req    = in_run && !busy && ((pend != '0) || (burst_left != '0));
  assign start      = wake_start || (run_req && grant_i);
  assign pend_dec   = cyc_done && in_run && (burst_left == '0);
  assign burst_take = burst_req_i && in_run && (burst_left == '0);

  rfs_timer #(.PERIOD(PAUSE_CYC)) u_pause (
    .clk(clk), .rst_n(rst_n), .en(mode == MD_PAUSE), .tick(pause_tick));

  rfs_timer #(.PERIOD(INTERVAL_CYC)) u_interval (
    .clk(clk), .rst_n(rst_n), .en(in_run), .tick(iv_tick));

  rfs_backlog #(.PEND_W(PEND_W), .URGENT_LVL(URGENT_LVL)) u_backlog (
    .clk(clk), .rst_n(rst_n), .inc(iv_tick), .dec(pend_dec),
    .count(pend), .urgent(urgent_o));

  rfs_cbr #(.T_CSR(T_CSR), .T_RAS(T_RAS), .T_CHR(T_CHR), .T_RP(T_RP)) u_cbr (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .cyc_done(cyc_done),
    .ras_n(ras_n_o), .cas_n(cas_n_o), .we_n(we_n_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= MD_PAUSE;
      wake_done <= '0;
    end else begin
      unique case (mode)
        MD_PAUSE: if (pause_tick) mode <= MD_WAKE;
        MD_WAKE: if (cyc_done) begin
          wake_done <= wake_done + 1'b1;
          if (wake_done == WKW'(WAKE_CNT - 1)) mode <= MD_RUN;
        end
        default: mode <= MD_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            burst_left <= '0;
    else if (burst_take)                   burst_left <= BSW'(BURST_CNT);
    else if (cyc_done && burst_left != '0) burst_left <= burst_left - 1'b1;
  end

  assign req_o       = run_req;
  assign bus_own_o   = busy;
  assign init_done_o = in_run;
  assign burst_act_o = (burst_left != '0);

  // R3
  no_early_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done_o |-> !req_o);
  // R3
  done_after_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done_o) |-> $past(cyc_done));
  // R11
  own_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_own_o) |-> $past(cyc_done));
  // R9
  urgent_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    urgent_o |-> (req_o || bus_own_o));
  // R10
  burst_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_act_o) |-> ($past(burst_req_i) && $past(init_done_o)));
endmodule

// File: tb/tb_rfs_seq.sv
module tb_rfs_seq;
  localparam int CLK_PERIOD = 10;
  localparam int PAUSE = 20, WAKE = 8, INTV = 80;
  localparam int CSR = 1, RASW = 4, CHR = 2, RP = 3;
  localparam int BURST = 6, PW = 3, URG = 3;
  localparam int LEN = CSR + RASW + RP;
  localparam int MAXB = (1 << PW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, grant_i = 1'b0, burst_req_i = 1'b0;
  logic req_o, bus_own_o, ras_n_o, cas_n_o, we_n_o, init_done_o, urgent_o, burst_act_o;

  rfs_seq #(.PAUSE_CYC(PAUSE), .WAKE_CNT(WAKE), .INTERVAL_CYC(INTV), .T_CSR(CSR),
            .T_RAS(RASW), .T_CHR(CHR), .T_RP(RP), .BURST_CNT(BURST), .PEND_W(PW),
            .URGENT_LVL(URG)) dut (
    .clk(clk), .rst_n(rst_n), .grant_i(grant_i), .burst_req_i(burst_req_i),
    .req_o(req_o), .bus_own_o(bus_own_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o),
    .we_n_o(we_n_o), .init_done_o(init_done_o), .urgent_o(urgent_o),
    .burst_act_o(burst_act_o));

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int ras_falls = 0, cas_falls = 0;
  logic prev_ras = 1'b1, prev_cas = 1'b1;
  bit done_flag = 0;

  // behavioural model: mode 0 pause, 1 wake-up, 2 running; pos -1 when idle
  int m_mode, m_pc, m_pos, m_wakes, m_back, m_burst, m_tct, m_ticks;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    bit rq, st, fin, tk, dc, tk_b;
    cyc++;
    if (!rst_n) begin
      m_mode = 0; m_pc = 0; m_pos = -1; m_wakes = 0;
      m_back = 0; m_burst = 0; m_tct = 0; m_ticks = 0;
    end else begin
      rq   = (m_mode == 2) && (m_pos < 0) && (m_back > 0 || m_burst > 0);
      st   = ((m_mode == 1) && (m_pos < 0) && (m_wakes < WAKE)) || (rq && grant_i);
      fin  = (m_pos == LEN - 1);
      tk   = (m_mode == 2) && (m_tct == INTV - 1);
      dc   = fin && (m_mode == 2) && (m_burst == 0);
      tk_b = burst_req_i && (m_mode == 2) && (m_burst == 0);
      if (tk && !dc) begin
        if (m_back < MAXB) m_back++;
      end else if (dc && !tk) m_back--;
      if (tk_b) m_burst = BURST;
      else if (fin && m_burst > 0) m_burst--;
      if (tk) m_ticks++;
      m_tct = (m_mode == 2) ? (tk ? 0 : m_tct + 1) : 0;
      if (m_mode == 0) begin
        if (m_pc == PAUSE - 1) m_mode = 1; else m_pc++;
      end else if (m_mode == 1 && fin) begin
        m_wakes++;
        if (m_wakes == WAKE) m_mode = 2;
      end
      if (m_pos >= 0) m_pos = fin ? -1 : m_pos + 1;
      else if (st) m_pos = 0;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      chk("R5 ras_n", int'(ras_n_o), int'(!(m_pos >= CSR && m_pos < CSR + RASW)));
      chk("R4 cas_n", int'(cas_n_o), int'(!(m_pos >= 0 && m_pos < CSR + CHR)));
      chk("R6 we_n", int'(we_n_o), 1);
      chk("R8 req", int'(req_o),
          int'((m_mode == 2) && (m_pos < 0) && (m_back > 0 || m_burst > 0)));
      chk("R11 bus_own", int'(bus_own_o), int'(m_pos >= 0));
      chk("R3 init_done", int'(init_done_o), int'(m_mode == 2));
      chk("R9 urgent", int'(urgent_o), int'(m_back > URG));
      chk("R10 burst_act", int'(burst_act_o), int'(m_burst > 0));
    end
    if (prev_ras && !ras_n_o) ras_falls++;
    if (prev_cas && !cas_n_o) cas_falls++;
    prev_ras = ras_n_o;
    prev_cas = cas_n_o;
  end

  always @(posedge clk) begin
    if (cyc > 20000 && !done_flag) begin
      chk("watchdog", 0, 1);
      finish_run();
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic wait_idle();
    int guard = 0;
    do begin step(1); guard++; end while ((req_o || bus_own_o) && guard < 500);
  endtask

  initial begin
    int f0, t0;
    step(3);
    // R1 reset state
    chk("R1 ras_n", int'(ras_n_o), 1);
    chk("R1 cas_n", int'(cas_n_o), 1);
    chk("R1 req", int'(req_o), 0);
    chk("R1 own", int'(bus_own_o), 0);
    chk("R1 done", int'(init_done_o), 0);
    chk("R1 burst", int'(burst_act_o), 0);
    rst_n = 1'b1;
    grant_i = 1'b1;          // R3: grant must not matter before init-done
    burst_req_i = 1'b1;      // R10: ignored during init
    step(1);
    burst_req_i = 1'b0;
    step(PAUSE - 4);
    // R2 quiet pause
    chk("R2 cas falls in pause", cas_falls, 0);
    chk("R2 own in pause", int'(bus_own_o), 0);
    chk("R10 burst ignored in init", int'(burst_act_o), 0);
    for (int g = 0; g < 400 && !init_done_o; g++) step(1);
    // R3 wake-up count
    chk("R3 wake cycles", ras_falls, WAKE);
    chk("R3 done reached", int'(init_done_o), 1);
    // steady running with grant
    step(300);
    // starve the bus until the backlog saturates
    grant_i = 1'b0;
    step(INTV * (MAXB + 3));
    t0 = m_ticks;
    while (m_ticks == t0) step(1);
    chk("R9 urgent when starved", int'(urgent_o), 1);
    f0 = ras_falls;
    grant_i = 1'b1;
    wait_idle();
    // R7 saturation visible as drained count
    chk("R7 drained cycles", ras_falls - f0, MAXB);
    chk("R9 urgent cleared", int'(urgent_o), 0);
    // burst
    f0 = ras_falls;
    burst_req_i = 1'b1;
    step(1);
    burst_req_i = 1'b0;
    chk("R10 burst loaded", int'(burst_act_o), 1);
    step(20);
    burst_req_i = 1'b1;      // R10: ignored while outstanding
    step(1);
    burst_req_i = 1'b0;
    for (int g = 0; g < 300 && burst_act_o; g++) step(1);
    chk("R10 burst cycles", ras_falls - f0, BURST);
    step(200);
    finish_run();
  end
endmodule